// File: doc/BRIEF.md
# Multi-Lane Word Serializer with Crossing Buffers

This block takes one parallel word per lane from core logic and turns each word into a serial bit stream on that lane's own output pin. A fast bit clock is an input. The block divides it by the word width to set the word boundaries and brings out the resulting word-rate clock. Each lane has a small dual-clock buffer. Core logic pushes into it on the core clock. The serializer pulls from it on the bit clock, once per word boundary.

Core logic writes into the lane buffers as a stream. A lane accepts its slice when that lane's valid bit is high at a core-clock edge and its full flag is low. The full flag is the inverse of ready: while it is high the producer must hold off. A beat offered while the flag is high is discarded and recorded. On the read side each lane has a valid/ready pair inside the block. The buffer's not-empty is valid, and the word boundary is ready. If no word is waiting at a boundary, the lane sends an all-zero idle word and records the underrun. A build option removes the buffers. In that build each serializer loads straight from the input bus at every boundary, and all flags stay low. One asynchronous clear input resets every lane, every buffer and the word timer.

Top module: `multi_lane_serializer`

## Requirements
- R1: Lane k takes its word from `tx_data[(k+1)*FACTOR-1 : k*FACTOR]`. Writing one lane never changes what another lane sends.
- R2: Each word goes out in FACTOR consecutive bit-clock cycles, most significant bit first, with no gap between words. The first bit of a word appears on `ser_out` in the bit-clock cycle in which `word_clk_o` goes high.
- R3: FACTOR must be 3 to 12, 14, 16, 18 or 20. Any other value stops elaboration.
- R4: A lane slice is accepted on a rising `core_clk` edge when its `tx_valid` bit is 1 and its `fifo_full` bit is 0. Accepted words leave that lane in the order they were accepted, and none is lost or repeated.
- R5: `fifo_full` rises when a lane's buffer (FIFO_DEPTH entries) holds FIFO_DEPTH words. A beat offered while it is 1 is dropped and sets that lane's sticky `overrun` bit. Other lanes' `overrun` bits are unaffected.
- R6: `fifo_empty` is 1 after clear and once a lane's buffer has drained.
- R7: When a lane's buffer is empty at a word boundary, that lane sends an all-zero word and sets its sticky `underrun` bit.
- R8: While `clr` is 1, every `ser_out` bit is 0, `word_clk_o` is 1, `fifo_empty` is all ones, and `fifo_full`, `overrun` and `underrun` are all zeros.
- R9: With BYPASS=1, each lane loads its `tx_data` slice directly at every word boundary. In that build `fifo_full`, `fifo_empty`, `overrun` and `underrun` are all 0.
- R10: `word_clk_o` has a period of FACTOR bit-clock cycles and is high for FACTOR/2 of them (rounded down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Fast serial bit clock |
| core_clk | input | 1 | Core-side write clock |
| clr | input | 1 | Asynchronous clear, active high |
| tx_data | input | NUM_LANES*FACTOR | Packed lane words, lane 0 in the low slice |
| tx_valid | input | NUM_LANES | Per-lane write valid |
| ser_out | output | NUM_LANES | Serial output per lane |
| word_clk_o | output | 1 | Word-rate clock |
| fifo_full | output | NUM_LANES | Per-lane full flag; acts as not-ready |
| fifo_empty | output | NUM_LANES | Per-lane empty flag |
| overrun | output | NUM_LANES | Sticky per-lane dropped-write flag |
| underrun | output | NUM_LANES | Sticky per-lane idle-word flag |

## Verification
The bench drives two flow-controlled lanes together with every nonzero 4-bit word, and gives lane 1 a different permutation of the same words. This exposes swapped slices, reversed bit order and lost or reordered entries. Lane 1 alone is then fed in slow, spaced writes, so idle words fall between data words and lane 0 must stay silent. A burst that ignores the full flag shows the drop-and-flag behaviour, and the received subsequence must still be strictly increasing. Idle runs after clear check the underrun path. Two asymmetric constant words on the bypass build show that it loads directly from the bus, with no buffer in the path.

// File: rtl/mcser_pkg.sv
package mcser_pkg;
  // Legal word widths for the serializer.
  function automatic bit factor_ok(input int f);
    return ((f >= 3) && (f <= 12)) || (f == 14) || (f == 16) || (f == 18) || (f == 20);
  endfunction
endpackage

// File: rtl/mcser_word_timer.sv
module mcser_word_timer #(
  parameter int FACTOR = 10
) (
  input  logic bit_clk,
  input  logic clr,
  output logic word_ld,
  output logic word_clk
);
  localparam int CW   = (FACTOR > 1) ? $clog2(FACTOR) : 1;
  localparam int HALF = FACTOR / 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  assign word_ld = (cnt == CW'(FACTOR - 1));
  assign cnt_nxt = word_ld ? '0 : cnt + 1'b1;

  always_ff @(posedge bit_clk or posedge clr) begin
    if (clr) begin
      cnt      <= '0;
      word_clk <= 1'b1;
    end else begin
      cnt      <= cnt_nxt;
      word_clk <= (cnt_nxt < CW'(HALF));
    end
  end
endmodule

// File: rtl/mcser_fifo.sv
module mcser_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 8
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             clr,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  output logic             overrun,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rq1, rq2, wq1, wq2;
  logic [PW-1:0] wbin_n, rbin_n;
  logic          push, pop;

  generate
    if ((DEPTH < 4) || ((1 << AW) != DEPTH)) begin : g_bad_depth
      $error("mcser_fifo: DEPTH must be a power of two, at least 4");
    end
  endgenerate

  // write side
  assign full   = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
  assign push   = wr_valid && !full;
  assign wbin_n = wbin + PW'(push);

  always_ff @(posedge wr_clk or posedge clr) begin
    if (clr) begin
      wbin    <= '0;
      wgray   <= '0;
      rq1     <= '0;
      rq2     <= '0;
      overrun <= 1'b0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
      rq1   <= rgray;
      rq2   <= rq1;
      if (wr_valid && full) overrun <= 1'b1;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (push) mem[wbin[AW-1:0]] <= wr_data;
  end

  // read side
  assign empty   = (rgray == wq2);
  assign pop     = rd_ready && !empty;
  assign rbin_n  = rbin + PW'(pop);
  assign rd_data = mem[rbin[AW-1:0]];

  always_ff @(posedge rd_clk or posedge clr) begin
    if (clr) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
    end else begin
      rbin  <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
      wq1   <= wgray;
      wq2   <= wq1;
    end
  end
endmodule

// File: rtl/mcser_lane.sv
module mcser_lane #(
  parameter int FACTOR = 10
) (
  input  logic              bit_clk,
  input  logic              clr,
  input  logic              word_ld,
  input  logic              src_valid,
  input  logic [FACTOR-1:0] src_word,
  output logic              ser,
  output logic              underrun
);
  logic [FACTOR-1:0] sh;

  assign ser = sh[FACTOR-1];

  always_ff @(posedge bit_clk or posedge clr) begin
    if (clr) begin
      sh       <= '0;
      underrun <= 1'b0;
    end else if (word_ld) begin
      sh <= src_valid ? src_word : '0;
      if (!src_valid) underrun <= 1'b1;
    end else begin
      sh <= {sh[FACTOR-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/multi_lane_serializer.sv
module multi_lane_serializer
  import mcser_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int FACTOR     = 10,
  parameter int FIFO_DEPTH = 8,
  parameter bit BYPASS     = 1'b0
) (
  input  logic                          bit_clk,
  input  logic                          core_clk,
  input  logic                          clr,
  input  logic [NUM_LANES*FACTOR-1:0]   tx_data,
  input  logic [NUM_LANES-1:0]          tx_valid,
  output logic [NUM_LANES-1:0]          ser_out,
  output logic                          word_clk_o,
  output logic [NUM_LANES-1:0]          fifo_full,
  output logic [NUM_LANES-1:0]          fifo_empty,
  output logic [NUM_LANES-1:0]          overrun,
  output logic [NUM_LANES-1:0]          underrun
);
  generate
    if (!factor_ok(FACTOR)) begin : g_bad_factor
      $error("multi_lane_serializer: illegal FACTOR");
    end
  endgenerate

  logic word_ld;

  mcser_word_timer #(.FACTOR(FACTOR)) u_timer (
    .bit_clk  (bit_clk),
    .clr      (clr),
    .word_ld  (word_ld),
    .word_clk (word_clk_o)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic              src_valid;
    logic [FACTOR-1:0] src_word;

    if (BYPASS) begin : g_direct
      assign src_valid     = 1'b1;
      assign src_word      = tx_data[l*FACTOR +: FACTOR];
      assign fifo_full[l]  = 1'b0;
      assign fifo_empty[l] = 1'b0;
      assign overrun[l]    = 1'b0;
    end else begin : g_buf
      logic empty_l;
      mcser_fifo #(.WIDTH(FACTOR), .DEPTH(FIFO_DEPTH)) u_fifo (
        .wr_clk   (core_clk),
        .rd_clk   (bit_clk),
        .clr      (clr),
        .wr_valid (tx_valid[l]),
        .wr_data  (tx_data[l*FACTOR +: FACTOR]),
        .full     (fifo_full[l]),
        .overrun  (overrun[l]),
        .rd_ready (word_ld),
        .rd_data  (src_word),
        .empty    (empty_l)
      );
      assign src_valid     = !empty_l;
      assign fifo_empty[l] = empty_l;
    end

    mcser_lane #(.FACTOR(FACTOR)) u_lane (
      .bit_clk   (bit_clk),
      .clr       (clr),
      .word_ld   (word_ld),
      .src_valid (src_valid),
      .src_word  (src_word),
      .ser       (ser_out[l]),
      .underrun  (underrun[l])
    );
  end
endmodule

// File: rtl/mcser_chk.sv
module mcser_chk #(
  parameter int NL = 4
) (
  input logic          bit_clk,
  input logic          core_clk,
  input logic          clr,
  input logic          word_ld,
  input logic          word_clk_o,
  input logic [NL-1:0] ser_out,
  input logic [NL-1:0] fifo_empty,
  input logic [NL-1:0] overrun,
  input logic [NL-1:0] underrun
);
  for (genvar l = 0; l < NL; l++) begin : g_chk
    assert_idle_zero_R7: assert property (@(posedge bit_clk) disable iff (clr)
      (word_ld && fifo_empty[l]) |=> (!ser_out[l] && underrun[l]));
    assert_underrun_sticky_R7: assert property (@(posedge bit_clk) disable iff (clr)
      underrun[l] |=> underrun[l]);
    assert_overrun_sticky_R5: assert property (@(posedge core_clk) disable iff (clr)
      overrun[l] |=> overrun[l]);
  end

  assert_wclk_rise_R10: assert property (@(posedge bit_clk) disable iff (clr)
    word_ld |=> $rose(word_clk_o));

  assert_clear_R8: assert property (@(posedge bit_clk)
    clr |-> ((ser_out == '0) && (underrun == '0) && word_clk_o));
endmodule

bind multi_lane_serializer mcser_chk #(.NL(NUM_LANES)) u_chk (
  .bit_clk    (bit_clk),
  .core_clk   (core_clk),
  .clr        (clr),
  .word_ld    (word_ld),
  .word_clk_o (word_clk_o),
  .ser_out    (ser_out),
  .fifo_empty (fifo_empty),
  .overrun    (overrun),
  .underrun   (underrun)
);

// File: tb/multi_lane_serializer_tb.sv
`timescale 1ns/1ps
module multi_lane_serializer_tb;
  import mcser_pkg::*;
  localparam int NL = 2;
  localparam int F  = 4;

  logic bit_clk = 1'b0, core_clk = 1'b0, clr;
  logic [NL*F-1:0] tx_data, din_b;
  logic [NL-1:0]   tx_valid;
  logic [NL-1:0]   ser_a, full_a, empty_a, over_a, under_a;
  logic [NL-1:0]   ser_b, full_b, empty_b, over_b, under_b;
  logic            wclk_a, wclk_b;

  always #2   bit_clk  = ~bit_clk;   // 250 MHz
  always #2.5 core_clk = ~core_clk;

  multi_lane_serializer #(.NUM_LANES(NL), .FACTOR(F), .FIFO_DEPTH(8), .BYPASS(1'b0)) u_dut (
    .bit_clk(bit_clk), .core_clk(core_clk), .clr(clr), .tx_data(tx_data), .tx_valid(tx_valid),
    .ser_out(ser_a), .word_clk_o(wclk_a), .fifo_full(full_a), .fifo_empty(empty_a),
    .overrun(over_a), .underrun(under_a));

  multi_lane_serializer #(.NUM_LANES(NL), .FACTOR(F), .FIFO_DEPTH(8), .BYPASS(1'b1)) u_byp (
    .bit_clk(bit_clk), .core_clk(core_clk), .clr(clr), .tx_data(din_b), .tx_valid(tx_valid),
    .ser_out(ser_b), .word_clk_o(wclk_b), .fifo_full(full_b), .fifo_empty(empty_b),
    .overrun(over_b), .underrun(under_b));

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bit-stream monitor, both instances
  logic [F-1:0] acc [2][NL];
  int           pos [2][NL];
  logic [F-1:0] rx [2][NL][64];
  int           rx_n [2][NL];
  logic [F-1:0] last_w [2][NL];
  int           ones [NL];
  logic         prev [2];
  int           since [2], per [2], hi_run [2], hi_last [2];
  logic         w, s, rise;
  bit           full_seen;

  always @(negedge bit_clk) begin
    for (int i = 0; i < 2; i++) begin
      w = (i == 0) ? wclk_a : wclk_b;
      rise = w && !prev[i];
      if (rise) begin
        per[i] = since[i]; since[i] = 1; hi_last[i] = hi_run[i]; hi_run[i] = 1;
      end else begin
        since[i]++;
        if (w) hi_run[i]++;
      end
      prev[i] = w;
      for (int l = 0; l < NL; l++) begin
        s = (i == 0) ? ser_a[l] : ser_b[l];
        if (i == 0 && s) ones[l]++;
        if (rise) begin
          acc[i][l] = {{(F-1){1'b0}}, s}; pos[i][l] = 1;
        end else if (pos[i][l] > 0) begin
          acc[i][l] = {acc[i][l][F-2:0], s}; pos[i][l]++;
        end
        if (pos[i][l] == F) begin
          pos[i][l] = 0;
          last_w[i][l] = acc[i][l];
          if (acc[i][l] != '0 && rx_n[i][l] < 64) begin
            rx[i][l][rx_n[i][l]] = acc[i][l];
            rx_n[i][l]++;
          end
        end
      end
    end
  end

  always @(negedge core_clk) if (full_a[0]) full_seen = 1'b1;

  task automatic settle();
    @(posedge bit_clk); #0.3;
  endtask

  task automatic clear_counts();
    settle();
    for (int l = 0; l < NL; l++) begin rx_n[0][l] = 0; ones[l] = 0; end
    full_seen = 1'b0;
  endtask

  task automatic clear_pulse();
    @(negedge bit_clk); clr = 1'b1;
    #10;
    @(negedge bit_clk); clr = 1'b0;
  endtask

  initial begin
    clr = 1'b0; tx_data = '0; tx_valid = '0;
    din_b = {4'h2, 4'hC};
    prev[0] = 1'b1; prev[1] = 1'b1;
    #1 clr = 1'b1;
    #40;
    // R8 reset state
    chk("R8 ser_out", int'(ser_a), 0);
    chk("R8 word_clk", int'(wclk_a), 1);
    chk("R8 empty", int'(empty_a), 3);
    chk("R8 full", int'(full_a), 0);
    chk("R8 overrun", int'(over_a), 0);
    chk("R8 underrun", int'(under_a), 0);
    @(negedge bit_clk); clr = 1'b0;

    // R7 idle after clear
    clear_counts();
    repeat (24) @(posedge bit_clk);
    settle();
    chk("R7 underrun set", int'(under_a), 3);
    chk("R7 idle zero lane0", ones[0], 0);
    chk("R7 idle zero lane1", ones[1], 0);
    chk("R6 empty when idle", int'(empty_a), 3);
    @(negedge bit_clk); clr = 1'b1; #10;
    chk("R8 clear resets underrun", int'(under_a), 0);
    @(negedge bit_clk); clr = 1'b0;

    // Phase A: both lanes, flow controlled, exhaustive nonzero words
    clear_counts();
    for (int i = 0; i < 30; i++) begin
      @(negedge core_clk);
      while (full_a != '0) @(negedge core_clk);
      tx_data = {4'((((i % 15) + 1) * 7) % 16), 4'((i % 15) + 1)};
      tx_valid = 2'b11;
      @(negedge core_clk);
      tx_valid = 2'b00;
    end
    #3000; settle();
    chk("R4 lane0 count", rx_n[0][0], 30);
    chk("R4 lane1 count", rx_n[0][1], 30);
    for (int i = 0; i < 30; i++) begin
      chk("R1 R2 R4 lane0 word", int'(rx[0][0][i]), (i % 15) + 1);
      chk("R1 R2 R4 lane1 word", int'(rx[0][1][i]), (((i % 15) + 1) * 7) % 16);
    end
    chk("R10 period", per[0], F);
    chk("R10 high time", hi_last[0], F / 2);
    chk("R6 empty after drain", int'(empty_a), 3);
    chk("R5 no overrun under flow control", int'(over_a), 0);

    // Phase B: lane 1 only, spaced writes
    clear_pulse();
    clear_counts();
    for (int v = 1; v < 16; v++) begin
      @(negedge core_clk);
      tx_data = {4'(v), 4'hF};
      tx_valid = 2'b10;
      @(negedge core_clk);
      tx_valid = 2'b00;
      #60;
    end
    #1000; settle();
    chk("R1 lane0 untouched", rx_n[0][0], 0);
    chk("R4 lane1 spaced count", rx_n[0][1], 15);
    for (int v = 1; v < 16; v++)
      chk("R2 R4 lane1 spaced word", int'(rx[0][1][v-1]), v);

    // Overrun burst on lane 0
    clear_pulse();
    clear_counts();
    @(negedge core_clk);
    tx_valid = 2'b01;
    for (int v = 1; v < 16; v++) begin
      tx_data = {4'h0, 4'(v)};
      @(negedge core_clk);
    end
    tx_valid = 2'b00;
    #2000; settle();
    chk("R5 full seen", int'(full_seen), 1);
    chk("R5 overrun lane0 only", int'(over_a), 1);
    chk("R5 full clears after drain", int'(full_a), 0);
    chk("R6 empty after burst", int'(empty_a), 3);
    chk("R5 some words dropped", int'(rx_n[0][0] >= 8 && rx_n[0][0] <= 14), 1);
    chk("R4 first kept word", int'(rx[0][0][0]), 1);
    for (int j = 1; j < rx_n[0][0]; j++)
      chk("R4 kept order", int'(rx[0][0][j] > rx[0][0][j-1]), 1);

    // Bypass build
    chk("R9 bypass lane0 word", int'(last_w[1][0]), 12);
    chk("R9 bypass lane1 word", int'(last_w[1][1]), 2);
    chk("R9 bypass flags", int'({full_b, empty_b, over_b, under_b}), 0);
    @(negedge bit_clk); din_b = {4'hE, 4'h1};
    repeat (12) @(posedge bit_clk);
    settle();
    chk("R9 bypass lane0 new", int'(last_w[1][0]), 1);
    chk("R9 bypass lane1 new", int'(last_w[1][1]), 14);
    chk("R10 bypass period", per[1], F);

    // R3 legal width set
    for (int f = 1; f <= 24; f++)
      chk("R3 factor legality", int'(factor_ok(f)),
          int'((f >= 3 && f <= 12) || f == 14 || f == 16 || f == 18 || f == 20));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule